// File: doc/BRIEF.md
# Isochronous Receive Trailer-First Reformatter

This block sits between the link layer's isochronous receive path and a host-side FIFO. Each arriving packet is a stream of 32-bit quadlets: one header quadlet, zero or more payload quadlets, and a closing status quadlet. The closing quadlet is flagged by `in_last`. The block keeps the header and payload in a local buffer, holds the status quadlet in a register, and checks the packet's size. It then writes the status quadlet to the FIFO first, followed by the header and the payload in the order they arrived.

The payload byte count comes from the header's length field in bits [31:16]. A valid packet has exactly ceil(length/4)+2 quadlets. Any other count causes a drop: nothing is written and `drop_err` pulses. A drop also happens when the payload is larger than the buffer, which holds `MAX_DATA_QUADS` payload quadlets plus the header.

While a packet waits to be written, input is stalled with `in_ready` low. The FIFO side is held off by `fifo_full`.

Top module: `iso_rx_reorder`

## Requirements
- R1: After reset, `in_ready` is 1, `fifo_wr_en` is 0 and `drop_err` is 0.
- R2: The first quadlet written for an accepted packet equals that packet's closing status quadlet. The bench uses speed bits [31:30], quadlet count [28:16], error code [3:0] and zeros elsewhere.
- R3: After the status quadlet, the header and then every payload quadlet are written in their arrival order.
- R4: An accepted packet of N input quadlets produces exactly N FIFO writes.
- R5: The payload length is header bits [31:16] in bytes. A packet whose quadlet count is not ceil(length/4)+2 produces no FIFO write and exactly one `drop_err` pulse. This includes a packet whose header carries `in_last`.
- R6: `fifo_wr_en` is never high while `fifo_full` is high. While the output is stalled by `fifo_full`, `fifo_wr_data` holds its value.
- R7: From the cycle after a packet's closing quadlet is accepted, `in_ready` stays low until the last write of that packet. It is never high in a cycle with `fifo_wr_en` high. After a drop, `in_ready` stays high.
- R8: A packet with more than `MAX_DATA_QUADS` payload quadlets is dropped as in R5, and the next packet is delivered normally.
- R9: A zero-length packet (header and status only) produces two writes: the status quadlet, then the header.
- R10: `drop_err` is high for one cycle, in the cycle right after the closing quadlet of a dropped packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input quadlet valid |
| in_data | input | 32 | Input quadlet |
| in_last | input | 1 | Marks the closing status quadlet of a packet |
| in_ready | output | 1 | Block accepts an input quadlet this cycle |
| fifo_full | input | 1 | Host FIFO cannot take a write |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | FIFO write data |
| drop_err | output | 1 | One-cycle pulse when a packet is dropped |

## Verification
The checker tests the following on every cycle:
- no write while the FIFO is full, and stable data during a full stall;
- input stall after an accepted closing quadlet, and no overlap of input acceptance with writes;
- the first write after a packet matches the closing quadlet captured at the input;
- a drop pulse only right after a closing quadlet.

Payload ordering, exact write counts, the length-to-count rule and its rounding, oversize handling and recovery after drops can only be shown by the bench's packet scenarios, which compare the captured FIFO stream against packets built from the requirements.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;

  localparam int QUAD_W = 32;
  localparam int LEN_W  = 16;
  localparam int EXP_W  = 15;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_STAT = 2'd1,
    ST_BODY = 2'd2
  } rx_state_e;

  function automatic logic [LEN_W-1:0] hdr_byte_len(input logic [QUAD_W-1:0] q);
    return q[31:16];
  endfunction

  // header + payload quadlets implied by a byte length
  function automatic logic [EXP_W-1:0] body_quads(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] rounded;
    rounded = {1'b0, len} + 17'd3;
    return EXP_W'(rounded >> 2) + EXP_W'(1);
  endfunction

endpackage

// File: rtl/iso_rx_store.sv
module iso_rx_store #(
  parameter int DEPTH = 17,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/iso_rx_len_chk.sv
module iso_rx_len_chk
  import iso_rx_pkg::*;
#(
  parameter int BODY_DEPTH = 17,
  localparam int CW        = $clog2(BODY_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_en,
  input  logic             beat_last,
  input  logic [LEN_W-1:0] beat_len,
  output logic [CW-1:0]    body_cnt,
  output logic             wr_allow,
  output logic             pkt_ok
);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [EXP_W-1:0] exp_q, exp_d;
  logic             cnt_en;

  assign cnt_en = beat_en;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    exp_d = exp_q;
    if (beat_last) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (cnt_q == '0) begin
        exp_d = body_quads(beat_len);
      end
      if (cnt_q == CW'(BODY_DEPTH)) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      exp_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      exp_q <= exp_d;
    end
  end

  assign body_cnt = cnt_q;
  assign wr_allow = (cnt_q < CW'(BODY_DEPTH));
  assign pkt_ok   = !ovf_q && (cnt_q != '0) && (EXP_W'(cnt_q) == exp_q);

endmodule

// File: rtl/iso_rx_reorder.sv
module iso_rx_reorder
  import iso_rx_pkg::*;
#(
  parameter int MAX_DATA_QUADS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [QUAD_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              fifo_full,
  output logic              fifo_wr_en,
  output logic [QUAD_W-1:0] fifo_wr_data,
  output logic              drop_err
);

  localparam int BODY_DEPTH = MAX_DATA_QUADS + 1;
  localparam int CW         = $clog2(BODY_DEPTH + 1);
  localparam int AW         = (BODY_DEPTH > 1) ? $clog2(BODY_DEPTH) : 1;

  rx_state_e         state_q, state_d;
  logic [QUAD_W-1:0] stat_q;
  logic [CW-1:0]     len_q;
  logic [CW-1:0]     rd_q, rd_d;
  logic              err_q, err_d;

  logic              accept;
  logic              ld_pkt;
  logic              rd_en;
  logic              st_en;
  logic              mem_we;
  logic [CW-1:0]     body_cnt;
  logic              wr_allow;
  logic              pkt_ok;
  logic [QUAD_W-1:0] rdata;

  assign in_ready = (state_q == ST_FILL);
  assign accept   = in_valid && in_ready;
  assign mem_we   = accept && !in_last && wr_allow;

  iso_rx_len_chk #(
    .BODY_DEPTH (BODY_DEPTH)
  ) u_len (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_en   (accept),
    .beat_last (in_last),
    .beat_len  (hdr_byte_len(in_data)),
    .body_cnt  (body_cnt),
    .wr_allow  (wr_allow),
    .pkt_ok    (pkt_ok)
  );

  iso_rx_store #(
    .DEPTH (BODY_DEPTH),
    .W     (QUAD_W)
  ) u_store (
    .clk   (clk),
    .we    (mem_we),
    .waddr (AW'(body_cnt)),
    .wdata (in_data),
    .raddr (AW'(rd_q)),
    .rdata (rdata)
  );

  always_comb begin
    state_d      = state_q;
    rd_d         = rd_q;
    err_d        = 1'b0;
    ld_pkt       = 1'b0;
    fifo_wr_en   = 1'b0;
    fifo_wr_data = rdata;
    unique case (state_q)
      ST_FILL: begin
        if (accept && in_last) begin
          if (pkt_ok) begin
            ld_pkt  = 1'b1;
            rd_d    = '0;
            state_d = ST_STAT;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_STAT: begin
        fifo_wr_data = stat_q;
        if (!fifo_full) begin
          fifo_wr_en = 1'b1;
          state_d    = ST_BODY;
        end
      end
      ST_BODY: begin
        if (!fifo_full) begin
          fifo_wr_en = 1'b1;
          rd_d       = rd_q + CW'(1);
          if (rd_q == len_q - CW'(1)) begin
            state_d = ST_FILL;
          end
        end
      end
      default: state_d = ST_FILL;
    endcase
  end

  assign rd_en = ld_pkt || (fifo_wr_en && (state_q == ST_BODY));
  assign st_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
    end else if (st_en) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      len_q  <= '0;
    end else if (ld_pkt) begin
      stat_q <= in_data;
      len_q  <= body_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign drop_err = err_q;

endmodule

// File: rtl/iso_rx_reorder_chk.sv
module iso_rx_reorder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_data,
  input logic        in_last,
  input logic        in_ready,
  input logic        fifo_full,
  input logic        fifo_wr_en,
  input logic [31:0] fifo_wr_data,
  input logic        drop_err
);

  logic        last_acc;
  logic [31:0] trl_q;
  logic        first_q;

  assign last_acc = in_valid && in_ready && in_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trl_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (last_acc) begin
        trl_q   <= in_data;
        first_q <= 1'b1;
      end else if (fifo_wr_en) begin
        first_q <= 1'b0;
      end
    end
  end

  assert_no_write_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr_en);

  assert_hold_data_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && fifo_full) |=> $stable(fifo_wr_data));

  assert_stall_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_acc |=> (!in_ready || drop_err));

  assert_no_accept_during_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_en |-> !in_ready);

  assert_trailer_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_en && first_q) |-> (fifo_wr_data == trl_q));

  assert_drop_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> $past(last_acc));

endmodule

bind iso_rx_reorder iso_rx_reorder_chk u_chk (.*);

// File: tb/iso_rx_reorder_bench.sv
`timescale 1ns/1ps
module iso_rx_reorder_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_last;
  logic        in_ready;
  logic        fifo_full;
  logic        fifo_wr_en;
  logic [31:0] fifo_wr_data;
  logic        drop_err;

  int total = 0;
  int bad   = 0;
  logic [31:0] cap [32];
  int cap_n = 0;
  int err_n = 0;
  int full_wr = 0;
  bit bp_mode = 1'b0;
  int bp_cnt = 0;

  // {length bytes, payload quads sent, expect accepted}
  localparam logic [24:0] VEC [8] = '{
    {16'd8,  8'd2,  1'b1},
    {16'd5,  8'd2,  1'b1},
    {16'd0,  8'd0,  1'b1},
    {16'd3,  8'd1,  1'b1},
    {16'd64, 8'd16, 1'b1},
    {16'd8,  8'd3,  1'b0},
    {16'd12, 8'd2,  1'b0},
    {16'd68, 8'd17, 1'b0}
  };

  iso_rx_reorder u_iso_rx_reorder (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_data      (in_data),
    .in_last      (in_last),
    .in_ready     (in_ready),
    .fifo_full    (fifo_full),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .drop_err     (drop_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    bp_cnt = bp_cnt + 1;
    fifo_full = bp_mode && ((bp_cnt % 3) != 0);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_wr_en) begin
        if (cap_n < 32) cap[cap_n] = fifo_wr_data;
        cap_n = cap_n + 1;
        if (fifo_full) full_wr = full_wr + 1;
      end
      if (drop_err) err_n = err_n + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] d, input logic l);
    in_valid = 1'b1;
    in_data  = d;
    in_last  = l;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk_hdr(input logic [15:0] len);
    return {len, 2'b00, 6'd5, 4'hA, 4'h0};
  endfunction

  function automatic logic [31:0] mk_trl(input int nq);
    return {2'b10, 1'b0, 13'(nq), 12'h000, 4'h3};
  endfunction

  task automatic run_pkt(input int id, input logic [15:0] len, input int nd,
                         input bit ok, input string rq);
    logic [31:0] hdr;
    logic [31:0] trl;
    int ord_bad;
    hdr = mk_hdr(len);
    trl = mk_trl(nd + 2);
    cap_n = 0;
    err_n = 0;
    beat(hdr, 1'b0);
    for (int k = 0; k < nd; k++) beat(32'hD000_0000 | (id << 8) | k, 1'b0);
    beat(trl, 1'b1);
    in_valid = 1'b0;
    in_last  = 1'b0;
    wait_idle();
    if (ok) begin
      chk(cap_n == nd + 2, "R4", {rq, " write count"}, cap_n, nd + 2);
      chk(cap[0] === trl, "R2", {rq, " status first"}, cap[0], trl);
      chk(cap[1] === hdr, "R3", {rq, " header second"}, cap[1], hdr);
      ord_bad = 0;
      for (int k = 0; k < nd; k++)
        if (cap[k + 2] !== (32'hD000_0000 | (id << 8) | k)) ord_bad++;
      chk(ord_bad == 0, "R3", {rq, " payload order"}, ord_bad, 0);
      chk(err_n == 0, "R10", {rq, " no drop pulse"}, err_n, 0);
    end else begin
      chk(cap_n == 0, "R5", {rq, " dropped writes"}, cap_n, 0);
      chk(err_n == 1, "R10", {rq, " one drop pulse"}, err_n, 1);
    end
  endtask

  initial begin
    #(5ns * 150000);
    bad = bad + 1;
    total = total + 1;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    in_last = 1'b0;
    fifo_full = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(fifo_wr_en == 1'b0, "R1", "no write after reset", fifo_wr_en, 0);
    chk(drop_err == 1'b0, "R1", "no drop after reset", drop_err, 0);
    @(posedge clk);
    #1;

    for (int i = 0; i < 8; i++) begin
      run_pkt(i, VEC[i][24:9], int'(VEC[i][8:1]), VEC[i][0],
              (VEC[i][8:1] == 8'd17) ? "R8 oversize" : "vector");
    end

    // R8: normal delivery after an oversize drop
    run_pkt(20, 16'd16, 4, 1'b1, "R8 recovery");

    // R9: zero-length packet
    run_pkt(21, 16'd0, 0, 1'b1, "R9 empty");

    // R5: header carries the end marker
    cap_n = 0;
    err_n = 0;
    beat(mk_hdr(16'd0), 1'b1);
    in_valid = 1'b0;
    in_last = 1'b0;
    wait_idle();
    chk(err_n == 1 && cap_n == 0, "R5", "header-only drop", err_n, 1);

    // R7: stall right after the closing quadlet, released at the end
    cap_n = 0;
    beat(mk_hdr(16'd4), 1'b0);
    beat(32'hCAFE_0001, 1'b0);
    beat(mk_trl(3), 1'b1);
    in_valid = 1'b0;
    in_last = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b0, "R7", "stall after last", in_ready, 0);
    wait_idle();
    chk(cap_n == 3 && in_ready, "R7", "released after drain", cap_n, 3);

    // R6: random-ish backpressure
    bp_mode = 1'b1;
    full_wr = 0;
    run_pkt(30, 16'd40, 10, 1'b1, "R6 backpressure");
    chk(full_wr == 0, "R6", "no write while full", full_wr, 0);
    bp_mode = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule